// File: doc/BRIEF.md
# Byte-Parallel LFSR Noise Source

A 32-bit Fibonacci shift register produces pseudo-random noise from a fixed set of XNOR taps. Each enabled clock advances the register by one position or by eight positions, chosen by a mode input. The eight-position advance computes all eight feedback bits at once, so a new random byte is available every cycle instead of every eighth cycle.

A seed can be loaded at any time. A seed that would lock the register is replaced with a fixed legal value. The full state, a serial random bit and the most recent random byte are all visible at the ports. A typical user loads a seed once, holds the step enable high, and reads either the serial bit (single-bit mode) or the byte output (byte mode).

Top module: `prng_byte_lfsr`

## Requirements
- R1: After synchronous reset the state is 32'h0000_0001 and the random-byte output is 8'h00.
- R2: A single-bit step (step high, byte_mode low) produces {s[30:0], f}, where f = NOT(s[31] XOR s[29] XOR s[25] XOR s[24]).
- R3: The serial random output always equals state bit 31.
- R4: A byte step (step high, byte_mode high) leaves the state identical to the state after eight successive single-bit steps. Old bits [23:0] move to [31:8], and the eight new bits occupy [7:0].
- R5: In a byte step, the feedback bit that would have been generated first lands in bit 7 of the new low byte, and the last one lands in bit 0.
- R6: A seed load copies the seed into the state, except that an all-ones seed is replaced by 32'h5EED_0001.
- R7: When load and step are high in the same cycle, the load wins, no step takes place, and the random-byte output keeps its value.
- R8: With step and load both low, the state and the random-byte output keep their values, whatever byte_mode is.
- R9: After a byte step, the random-byte output equals the new state bits [7:0] in the following cycle. Single-bit steps and loads do not change it.
- R10: Starting from reset or from any loaded seed, the state never becomes all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Seed load strobe |
| seed | input | 32 | Seed value |
| step | input | 1 | Advance enable |
| byte_mode | input | 1 | 0: advance one bit, 1: advance eight bits |
| state_o | output | 32 | Current register state |
| rnd_bit | output | 1 | Serial random bit (state bit 31) |
| rnd_byte | output | 8 | Random byte from the latest byte step |

## Verification
A seed load and an advance request can arrive in the same cycle. In that case the load must win, and the byte output must keep the value from the last real byte step. The sweep asserts load with step in both modes, including with the all-ones seed. The resulting state must equal the seed or its substitute, and a later check confirms that no advance was applied on top of it. Every byte step is also compared against eight applications of a bit-serial model computed in the bench.

// File: rtl/prng_lfsr_pkg.sv
package prng_lfsr_pkg;
   parameter int unsigned LFSR_W    = 32;
   parameter int unsigned LFSR_STEP = 8;
   parameter int unsigned TAP_A     = 31;
   parameter int unsigned TAP_B     = 29;
   parameter int unsigned TAP_C     = 25;
   parameter int unsigned TAP_D     = 24;

   typedef enum logic {
      ADV_BIT  = 1'b0,
      ADV_BYTE = 1'b1
   } adv_mode_e;
endpackage

// File: rtl/prng_fb_xnor.sv
module prng_fb_xnor (
   input  logic [3:0] taps,
   output logic       fb
);
   always_comb fb = ~(taps[3] ^ taps[2] ^ taps[1] ^ taps[0]);
endmodule

// File: rtl/prng_byte_net.sv
module prng_byte_net #(
   parameter int unsigned W    = 32,
   parameter int unsigned STEP = 8,
   parameter int unsigned TA   = 31,
   parameter int unsigned TB   = 29,
   parameter int unsigned TC   = 25,
   parameter int unsigned TD   = 24,
   localparam int unsigned LO  = TD - (STEP - 1),
   localparam int unsigned HW  = W - LO
) (
   input  logic [HW-1:0]   s_hi,
   output logic [STEP-1:0] fb_vec
);
   if (TD < STEP) begin : g_bad_tap
      $error("lowest tap must lie above the replaced slice");
   end
   if (!(TA > TB && TB > TC && TC > TD) || TA != W - 1) begin : g_bad_order
      $error("taps must be strictly descending with the top tap at the MSB");
   end

   for (genvar j = 0; j < STEP; j++) begin : g_stage
      logic [3:0] tv;
      always_comb tv = {s_hi[TA - j - LO], s_hi[TB - j - LO],
                        s_hi[TC - j - LO], s_hi[TD - j - LO]};
      prng_fb_xnor u_fb (.taps(tv), .fb(fb_vec[STEP-1-j]));
   end
endmodule

// File: rtl/prng_seed_guard.sv
module prng_seed_guard #(
   parameter int unsigned   W       = 32,
   parameter logic [W-1:0]  SUB_VAL = 32'h5EED_0001
) (
   input  logic [W-1:0] seed_in,
   output logic [W-1:0] seed_out
);
   if (SUB_VAL == {W{1'b1}}) begin : g_bad_sub
      $error("substitute seed must not be the lock-up value");
   end

   always_comb begin
      seed_out = (seed_in == {W{1'b1}}) ? SUB_VAL : seed_in;
      assert (seed_out != {W{1'b1}}) else $error("guard passed lock-up seed");
   end
endmodule

// File: rtl/prng_byte_lfsr.sv
module prng_byte_lfsr
   import prng_lfsr_pkg::*;
#(
   parameter int unsigned       W        = LFSR_W,
   parameter int unsigned       STEP     = LFSR_STEP,
   parameter logic [W-1:0]      RST_SEED = 32'h0000_0001,
   parameter logic [W-1:0]      SUB_SEED = 32'h5EED_0001,
   localparam int unsigned      LO       = TAP_D - (STEP - 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [W-1:0]    seed,
   input  logic            step,
   input  logic            byte_mode,
   output logic [W-1:0]    state_o,
   output logic            rnd_bit,
   output logic [STEP-1:0] rnd_byte
);
   if (RST_SEED == {W{1'b1}}) begin : g_bad_rst
      $error("reset seed must not be the lock-up value");
   end
   if (STEP >= W) begin : g_bad_step
      $error("step width must be below register width");
   end

   logic [W-1:0]    st_q, st_d, seed_ok;
   logic [STEP-1:0] byte_q, fbv;
   adv_mode_e       mode;

   always_comb mode = adv_mode_e'(byte_mode);

   prng_seed_guard #(.W(W), .SUB_VAL(SUB_SEED)) u_guard (
      .seed_in(seed), .seed_out(seed_ok));

   prng_byte_net #(.W(W), .STEP(STEP), .TA(TAP_A), .TB(TAP_B),
                   .TC(TAP_C), .TD(TAP_D)) u_net (
      .s_hi(st_q[W-1:LO]), .fb_vec(fbv));

   always_comb begin
      st_d = st_q;
      if (load)                    st_d = seed_ok;
      else if (step && mode == ADV_BYTE) st_d = {st_q[W-STEP-1:0], fbv};
      else if (step)               st_d = {st_q[W-2:0], fbv[STEP-1]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= RST_SEED;
         byte_q <= '0;
      end else begin
         st_q <= st_d;
         if (!load && step && mode == ADV_BYTE) byte_q <= fbv;
      end
   end

   always_comb begin
      state_o  = st_q;
      rnd_bit  = st_q[W-1];
      rnd_byte = byte_q;
   end

   assert_no_lockup_R10: assert property (@(posedge clk) disable iff (rst)
      st_q != {W{1'b1}});
   assert_serial_tap_R3: assert property (@(posedge clk) disable iff (rst)
      rnd_bit == state_o[W-1]);
   assert_bit_shift_R2: assert property (@(posedge clk) disable iff (rst)
      (!load && step && !byte_mode) |=> st_q[W-1:1] == $past(st_q[W-2:0]));
   assert_byte_shift_R4: assert property (@(posedge clk) disable iff (rst)
      (!load && step && byte_mode) |=> st_q[W-1:STEP] == $past(st_q[W-STEP-1:0]));
   assert_byte_out_R9: assert property (@(posedge clk) disable iff (rst)
      (!load && step && byte_mode) |=> rnd_byte == st_q[STEP-1:0]);
   assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
      load |=> (st_q == (($past(seed) == {W{1'b1}}) ? SUB_SEED : $past(seed)))
               && $stable(rnd_byte));
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!load && !step) |=> $stable(st_q) && $stable(rnd_byte));
endmodule

// File: tb/prng_byte_lfsr_bench.sv
module prng_byte_lfsr_bench;
   localparam int CLK_P = 10;
   localparam logic [31:0] SUB = 32'h5EED_0001;

   logic        clk = 0, rst = 1, load = 0, step = 0, byte_mode = 0;
   logic [31:0] seed = '0;
   logic [31:0] state_o;
   logic        rnd_bit;
   logic [7:0]  rnd_byte;

   int total = 0, bad = 0;
   bit done = 0;
   logic [31:0] m_st;
   logic [7:0]  m_byte;

   always #(CLK_P/2) clk = ~clk;

   prng_byte_lfsr u_prng_byte_lfsr (
      .clk(clk), .rst(rst), .load(load), .seed(seed), .step(step),
      .byte_mode(byte_mode), .state_o(state_o), .rnd_bit(rnd_bit),
      .rnd_byte(rnd_byte));

   function automatic logic [31:0] one(input logic [31:0] s);
      return {s[30:0], ~(s[31] ^ s[29] ^ s[25] ^ s[24])};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk({req, " state"}, state_o, m_st);
      chk("R3 serial", {31'b0, rnd_bit}, {31'b0, m_st[31]});
      chk({req, " byte R9"}, {24'b0, rnd_byte}, {24'b0, m_byte});
      total++;
      if (state_o === 32'hFFFF_FFFF) begin
         bad++;
         $display("FAIL R10 act=%h exp=not all ones", state_o);
      end
   endtask

   // at negedge: apply inputs, advance model, wait edge, check
   task automatic cyc(input logic ld, input logic [31:0] sd,
                      input logic st, input logic md);
      string tag;
      load = ld; seed = sd; step = st; byte_mode = md;
      if (ld) begin
         m_st = (sd == 32'hFFFF_FFFF) ? SUB : sd;
         tag = (st) ? "R7" : "R6";
      end else if (st && md) begin
         for (int k = 0; k < 8; k++) m_st = one(m_st);
         m_byte = m_st[7:0];
         tag = "R4";
      end else if (st) begin
         m_st = one(m_st);
         tag = "R2";
      end else tag = "R8";
      @(posedge clk);
      #(CLK_P/4);
      check_all(tag);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] sd;
      logic        b0;
      @(negedge clk);
      @(negedge clk);
      rst = 0;
      #(CLK_P/4);
      m_st = 32'h0000_0001; m_byte = 8'h00;
      chk("R1 reset state", state_o, 32'h0000_0001);
      chk("R1 reset byte", {24'b0, rnd_byte}, 32'h0);
      @(negedge clk);

      // R5: first generated bit lands at bit 7
      cyc(1'b1, 32'hA5C3_1E77, 1'b0, 1'b0);
      b0 = ~(m_st[31] ^ m_st[29] ^ m_st[25] ^ m_st[24]);
      cyc(1'b0, '0, 1'b1, 1'b1);
      chk("R5 oldest bit at 7", {31'b0, rnd_byte[7]}, {31'b0, b0});

      // R8: idle with mode toggling
      cyc(1'b0, '0, 1'b0, 1'b1);
      cyc(1'b0, '0, 1'b0, 1'b0);

      // R6/R7: all-ones seed with simultaneous step in byte mode
      cyc(1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1);
      chk("R6 lockup substitute", state_o, SUB);

      for (int i = 0; i < 160; i++) begin
         sd = (i * 32'h9E37_79B9) ^ (i << 5);
         if (i % 17 == 3) sd = 32'hFFFF_FFFF;
         cyc(1'b1, sd, 1'b0, 1'b0);
         for (int k = 0; k < 40; k++) begin
            logic st, md, ld;
            md = ((i + k) % 3) != 0;
            st = (k % 7) != 6;
            ld = (k == 19) && (i % 4 == 0);
            cyc(ld, sd ^ 32'h0F0F_0F0F, st, md);
         end
      end

      // long byte run from reset seed
      rst = 1;
      @(posedge clk); #(CLK_P/4);
      m_st = 32'h0000_0001; m_byte = 8'h00;
      check_all("R1");
      @(negedge clk);
      rst = 0;
      for (int k = 0; k < 2000; k++) cyc(1'b0, '0, 1'b1, 1'b1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule